// File: doc/BRIEF.md
# Highway and Farm-Road Signal Controller

This block runs the signal lamps where a busy highway crosses a lightly used farm road. A four-phase state machine decides which road has right of way, and an interval timer inside the block measures the green and amber periods. A single car-present input from the farm road is the only request. Without a request, the highway stays green indefinitely. When a car is waiting, the highway still keeps green until a guaranteed minimum has elapsed. The farm road is then given green for only as long as a car is present, and never longer than the long interval. Each green is followed by an amber period of the short interval.

The phases are: highway go (highway green, farm red), highway warn (highway amber, farm red), farm go (farm green, highway red) and farm warn (farm amber, highway red). The transitions are:
- highway go to highway warn, when the long interval has elapsed and a car is present;
- highway warn to farm go, when the short interval has elapsed;
- farm go to farm warn, when the long interval has elapsed or no car is present;
- farm warn to highway go, when the short interval has elapsed.

Every transition emits a one-cycle restart pulse that clears the timer. The elapsed flags stay high from expiry until the next restart. Both intervals are parameters counted in clock cycles, with SHORT_CYC < LONG_CYC. Reset is synchronous and active high.

Top module: `hwy_farm_signal_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, the lamps show highway green and farm red, and the timer starts from zero. After reset the highway green therefore lasts exactly LONG_CYC+1 cycles when a car is waiting.
- R2: In every cycle after reset, exactly one of the three highway lamps and exactly one of the three farm lamps is lit. Farm red is lit in both highway phases, and highway red is lit in both farm phases.
- R3: With no car present, highway green holds indefinitely. With a car present from the moment highway green begins, highway green lasts exactly LONG_CYC+1 cycles.
- R4: Highway amber lasts exactly SHORT_CYC+1 cycles and is followed by farm green.
- R5: With a car present throughout, farm green lasts exactly LONG_CYC+1 cycles and is followed by farm amber.
- R6: When the car input is low during a farm-green cycle, the next cycle shows farm amber. This includes the first farm-green cycle, when the car left during highway amber.
- R7: Farm amber lasts exactly SHORT_CYC+1 cycles and is followed by highway green.
- R8: The phases change only in the order highway go, highway warn, farm go, farm warn, and back to highway go.
- R9: Once the minimum highway green has elapsed, the long-interval flag stays high. A car arriving later switches the highway to amber in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| car_present | input | 1 | A vehicle is waiting on the farm road |
| hwy_green | output | 1 | Highway green lamp |
| hwy_amber | output | 1 | Highway amber lamp |
| hwy_red | output | 1 | Highway red lamp |
| farm_green | output | 1 | Farm-road green lamp |
| farm_amber | output | 1 | Farm-road amber lamp |
| farm_red | output | 1 | Farm-road red lamp |

## Verification
The hardest case to reach from the ports is a farm-go phase that lasts a single cycle. The car has to request the crossing, and then vanish after the highway has committed to amber but before farm green appears. The bench raises the car input at the exact cycle highway green begins, lowers it on the first amber cycle, and then checks that farm green is seen for one sample only. It also reaches the saturated long-interval flag by idling the highway well past its minimum green, and only then presenting a car.

// File: rtl/sig_ctrl_pkg.sv
package sig_ctrl_pkg;

    typedef enum logic [1:0] {
        PH_HWY_GO    = 2'd0,
        PH_HWY_WARN  = 2'd1,
        PH_FARM_GO   = 2'd2,
        PH_FARM_WARN = 2'd3
    } phase_t;

    typedef struct packed {
        logic green;
        logic amber;
        logic red;
    } lamp_set_t;

endpackage

// File: rtl/sig_interval_timer.sv
module sig_interval_timer #(
    parameter int SHORT_CYC = 3,
    parameter int LONG_CYC  = 8,
    localparam int CNT_W    = $clog2(LONG_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    output logic             short_done,
    output logic             long_done,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_CYC);
    localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_CYC);

    logic [CNT_W-1:0] cnt_q;

    // Count up from zero after each restart and saturate at the long limit.
    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (cnt_q != LONG_LIM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign short_done = (cnt_q >= SHORT_LIM);
    assign long_done  = (cnt_q == LONG_LIM);
    assign count      = cnt_q;

endmodule

// File: rtl/sig_phase_fsm.sv
module sig_phase_fsm
    import sig_ctrl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   car_present,
    input  logic   short_done,
    input  logic   long_done,
    output phase_t phase,
    output logic   restart
);
    phase_t phase_q;
    phase_t phase_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_HWY_GO;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Transition decisions
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_HWY_GO:    if (long_done && car_present)    phase_d = PH_HWY_WARN;
            PH_HWY_WARN:  if (short_done)                  phase_d = PH_FARM_GO;
            PH_FARM_GO:   if (long_done || !car_present)   phase_d = PH_FARM_WARN;
            PH_FARM_WARN: if (short_done)                  phase_d = PH_HWY_GO;
            default:                                       phase_d = PH_HWY_GO;
        endcase
    end

    // One-cycle pulse on every taken transition
    assign restart = (phase_d != phase_q);
    assign phase   = phase_q;

endmodule

// File: rtl/sig_lamp_decode.sv
module sig_lamp_decode
    import sig_ctrl_pkg::*;
(
    input  phase_t    phase,
    output lamp_set_t hwy,
    output lamp_set_t farm
);
    always_comb begin
        hwy  = '{green: 1'b0, amber: 1'b0, red: 1'b1};
        farm = '{green: 1'b0, amber: 1'b0, red: 1'b1};
        unique case (phase)
            PH_HWY_GO:    hwy  = '{green: 1'b1, amber: 1'b0, red: 1'b0};
            PH_HWY_WARN:  hwy  = '{green: 1'b0, amber: 1'b1, red: 1'b0};
            PH_FARM_GO:   farm = '{green: 1'b1, amber: 1'b0, red: 1'b0};
            PH_FARM_WARN: farm = '{green: 1'b0, amber: 1'b1, red: 1'b0};
            default: begin
                hwy  = '{green: 1'b0, amber: 1'b0, red: 1'b1};
                farm = '{green: 1'b0, amber: 1'b0, red: 1'b1};
            end
        endcase
    end

endmodule

// File: rtl/hwy_farm_signal_ctrl.sv
module hwy_farm_signal_ctrl
    import sig_ctrl_pkg::*;
#(
    parameter int SHORT_CYC = 3,
    parameter int LONG_CYC  = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic car_present,
    output logic hwy_green,
    output logic hwy_amber,
    output logic hwy_red,
    output logic farm_green,
    output logic farm_amber,
    output logic farm_red
);
    localparam int CNT_W = $clog2(LONG_CYC + 1);

    logic             restart;
    logic             short_done;
    logic             long_done;
    logic [CNT_W-1:0] tmr_count;
    phase_t           phase;
    lamp_set_t        hwy_lamps;
    lamp_set_t        farm_lamps;

    sig_interval_timer #(
        .SHORT_CYC (SHORT_CYC),
        .LONG_CYC  (LONG_CYC)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .restart    (restart),
        .short_done (short_done),
        .long_done  (long_done),
        .count      (tmr_count)
    );

    sig_phase_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .car_present (car_present),
        .short_done  (short_done),
        .long_done   (long_done),
        .phase       (phase),
        .restart     (restart)
    );

    sig_lamp_decode u_lamps (
        .phase (phase),
        .hwy   (hwy_lamps),
        .farm  (farm_lamps)
    );

    assign hwy_green  = hwy_lamps.green;
    assign hwy_amber  = hwy_lamps.amber;
    assign hwy_red    = hwy_lamps.red;
    assign farm_green = farm_lamps.green;
    assign farm_amber = farm_lamps.amber;
    assign farm_red   = farm_lamps.red;

endmodule

// File: rtl/hwy_farm_signal_ctrl_chk.sv
module hwy_farm_signal_ctrl_chk #(
    parameter int SHORT_CYC = 3,
    parameter int LONG_CYC  = 8,
    localparam int CNT_W    = $clog2(LONG_CYC + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             car_present,
    input logic             hwy_green,
    input logic             hwy_amber,
    input logic             hwy_red,
    input logic             farm_green,
    input logic             farm_amber,
    input logic             farm_red,
    input logic [CNT_W-1:0] tmr_count
);
    localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_CYC);
    localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_CYC);

    // Run length of the current farm green, counted independently of the timer
    logic [CNT_W:0] fg_run;
    always_ff @(posedge clk) begin
        if (rst || !farm_green) fg_run <= '0;
        else                    fg_run <= fg_run + 1'b1;
    end

    a_r1_reset_phase: assert property (@(posedge clk)
        rst |=> (hwy_green && farm_red));

    a_r2_one_hwy_lamp: assert property (@(posedge clk) disable iff (rst)
        $countones({hwy_green, hwy_amber, hwy_red}) == 1);

    a_r2_one_farm_lamp: assert property (@(posedge clk) disable iff (rst)
        $countones({farm_green, farm_amber, farm_red}) == 1);

    a_r2_cross_red: assert property (@(posedge clk) disable iff (rst)
        (hwy_green || hwy_amber) == farm_red);

    a_r3_min_green: assert property (@(posedge clk) disable iff (rst)
        $rose(hwy_amber) |-> $past(tmr_count) == LONG_LIM);

    a_r4_amber_len: assert property (@(posedge clk) disable iff (rst)
        $rose(farm_green) |-> $past(tmr_count) == SHORT_LIM);

    a_r5_farm_cap: assert property (@(posedge clk) disable iff (rst)
        farm_green |-> fg_run <= {1'b0, LONG_LIM});

    a_r6_car_gone: assert property (@(posedge clk) disable iff (rst)
        (farm_green && !car_present) |=> farm_amber);

    a_r8_after_hwy_go: assert property (@(posedge clk) disable iff (rst)
        hwy_green |=> (hwy_green || hwy_amber));

    a_r8_after_hwy_warn: assert property (@(posedge clk) disable iff (rst)
        hwy_amber |=> (hwy_amber || farm_green));

    a_r8_after_farm_go: assert property (@(posedge clk) disable iff (rst)
        farm_green |=> (farm_green || farm_amber));

    a_r8_after_farm_warn: assert property (@(posedge clk) disable iff (rst)
        farm_amber |=> (farm_amber || hwy_green));

    a_r9_late_car: assert property (@(posedge clk) disable iff (rst)
        (hwy_green && car_present && tmr_count == LONG_LIM) |=> hwy_amber);

endmodule

bind hwy_farm_signal_ctrl hwy_farm_signal_ctrl_chk #(
    .SHORT_CYC (SHORT_CYC),
    .LONG_CYC  (LONG_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .car_present (car_present),
    .hwy_green   (hwy_green),
    .hwy_amber   (hwy_amber),
    .hwy_red     (hwy_red),
    .farm_green  (farm_green),
    .farm_amber  (farm_amber),
    .farm_red    (farm_red),
    .tmr_count   (tmr_count)
);

// File: tb/hwy_farm_signal_ctrl_tb.sv
`timescale 1ns/1ps
module hwy_farm_signal_ctrl_tb;

    localparam int SHORT_CYC = 3;
    localparam int LONG_CYC  = 8;
    localparam int L_HG = 5, L_HY = 4, L_HR = 3, L_FG = 2, L_FY = 1, L_FR = 0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic car_present = 1'b0;
    logic hwy_green, hwy_amber, hwy_red, farm_green, farm_amber, farm_red;
    logic [5:0] lamps;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    hwy_farm_signal_ctrl #(
        .SHORT_CYC (SHORT_CYC),
        .LONG_CYC  (LONG_CYC)
    ) u_dut (
        .clk         (clk),
        .rst         (rst),
        .car_present (car_present),
        .hwy_green   (hwy_green),
        .hwy_amber   (hwy_amber),
        .hwy_red     (hwy_red),
        .farm_green  (farm_green),
        .farm_amber  (farm_amber),
        .farm_red    (farm_red)
    );

    assign lamps = {hwy_green, hwy_amber, hwy_red, farm_green, farm_amber, farm_red};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count consecutive falling-edge samples on which the chosen lamp is lit
    task automatic measure_run(input int idx, output int n);
        n = 0;
        while (lamps[idx] && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // R2: lamp exclusivity on every sample after reset
    always @(negedge clk) begin
        if (!rst && !done) begin
            check($countones(lamps[5:3]) == 1, "R2 hwy lamps", int'(lamps[5:3]), 1);
            check($countones(lamps[2:0]) == 1, "R2 farm lamps", int'(lamps[2:0]), 1);
            check(farm_red == (hwy_green || hwy_amber), "R2 cross red", int'(farm_red), int'(hwy_green || hwy_amber));
        end
    end

    task automatic t_reset_state();
        @(negedge clk);
        check(hwy_green && farm_red, "R1 reset lamps", int'(lamps), 6'b100_001);
        rst = 1'b0;
    endtask

    task automatic t_idle_highway();
        for (int i = 0; i < 30; i++) begin
            check(hwy_green == 1'b1, "R3 idle highway green", int'(hwy_green), 1);
            @(negedge clk);
        end
    endtask

    task automatic t_late_car();
        car_present = 1'b1;
        @(negedge clk);
        check(hwy_amber == 1'b1, "R9 late car immediate amber", int'(hwy_amber), 1);
    endtask

    task automatic t_full_cycle();
        int n;
        measure_run(L_HY, n);
        check(n == SHORT_CYC + 1, "R4 highway amber length", n, SHORT_CYC + 1);
        check(farm_green == 1'b1, "R8 amber to farm green", int'(farm_green), 1);
        measure_run(L_FG, n);
        check(n == LONG_CYC + 1, "R5 farm green cap", n, LONG_CYC + 1);
        check(farm_amber == 1'b1, "R8 farm green to amber", int'(farm_amber), 1);
        measure_run(L_FY, n);
        check(n == SHORT_CYC + 1, "R7 farm amber length", n, SHORT_CYC + 1);
        check(hwy_green == 1'b1, "R8 farm amber to highway", int'(hwy_green), 1);
        measure_run(L_HG, n);
        check(n == LONG_CYC + 1, "R3 minimum highway green", n, LONG_CYC + 1);
    endtask

    task automatic t_car_leaves_farm();
        int n;
        measure_run(L_HY, n);
        check(farm_green == 1'b1, "R8 reach farm green", int'(farm_green), 1);
        @(negedge clk);
        car_present = 1'b0;
        @(negedge clk);
        check(farm_amber == 1'b1, "R6 car gone ends farm green", int'(farm_amber), 1);
        measure_run(L_FY, n);
        check(n == SHORT_CYC + 1, "R7 farm amber after early end", n, SHORT_CYC + 1);
    endtask

    task automatic t_car_leaves_amber();
        int n;
        check(hwy_green == 1'b1, "R8 back to highway", int'(hwy_green), 1);
        car_present = 1'b1;
        measure_run(L_HG, n);
        check(n == LONG_CYC + 1, "R3 green with car from entry", n, LONG_CYC + 1);
        car_present = 1'b0;
        measure_run(L_HY, n);
        check(n == SHORT_CYC + 1, "R4 amber unaffected by car", n, SHORT_CYC + 1);
        measure_run(L_FG, n);
        check(n == 1, "R6 single-cycle farm green", n, 1);
        check(farm_amber == 1'b1, "R6 farm amber follows", int'(farm_amber), 1);
    endtask

    task automatic t_reset_midway();
        int n;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(hwy_green && farm_red, "R1 mid-run reset lamps", int'(lamps), 6'b100_001);
        @(negedge clk);
        rst = 1'b0;
        car_present = 1'b1;
        measure_run(L_HG, n);
        check(n == LONG_CYC + 1, "R1 timer restarted by reset", n, LONG_CYC + 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        t_idle_highway();
        t_late_car();
        t_full_cycle();
        t_car_leaves_farm();
        t_car_leaves_amber();
        t_reset_midway();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        done = 1'b1;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule